// File: doc/BRIEF.md
# Reed-Solomon Syndrome Front End

This block is the first stage of a Reed-Solomon decoder for 15-symbol codewords over GF(16), with the field built from x^4+x+1. Received symbols arrive as 4-bit values, one per clock, on a stream with a valid strobe and a start-of-block marker. The block evaluates the received polynomial at the four consecutive roots 1, 2, 4 and 8 of the generator polynomial. It reports the four syndromes, together with a no-error flag, through a one-cycle result strobe.

Each root has its own Horner-rule accumulator. For every accepted symbol the accumulator is multiplied by its fixed root and the new symbol is added. The multiplication by a constant uses a 16-entry table that is computed at elaboration time. The root-1 accumulator has no table and simply XORs the symbols together. Results sit in output registers, so the next block can start in the cycle right after the last symbol of the previous one. The later decoder stages read the syndromes at their own pace until the next strobe.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While and right after reset, syn_valid is 0, syn_out is all zeros and no_err is 0.
- R2: For a block r_0..r_14, with r_0 the first accepted symbol and the highest-degree coefficient, syndrome S_j = XOR over i of r_i·α^(j·(14−i)) in GF(16) with x^4+x+1 and α=2, for j=0..3. S_j is placed at syn_out[4j+3:4j].
- R3: syn_valid is a single-cycle pulse in the cycle after the 15th accepted symbol of a block, and it occurs at no other time.
- R4: no_err equals 1 exactly when all 16 syndrome bits presented with the pulse are zero, and it is held with them.
- R5: A cycle with sym_valid low adds no symbol and does not advance the block, so stalls anywhere in a block leave the syndromes unchanged.
- R6: sym_valid with sym_sob high always starts a new block with that symbol as r_0, and it discards any partial block.
- R7: Symbols with sym_valid high and sym_sob low while no block is open are ignored: they produce no pulse and leave the outputs unchanged.
- R8: A new block may start in the cycle right after the 15th symbol. Both blocks then yield correct, separate results.
- R9: syn_out and no_err change only at the edge that raises syn_valid and stay stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_sob | input | 1 | Symbol is the first of a block |
| sym_data | input | 4 | Received symbol |
| syn_valid | output | 1 | One-cycle strobe: syndromes updated |
| syn_out | output | 16 | S3..S0, four bits each, S0 in the low nibble |
| no_err | output | 1 | All syndromes zero |

## Verification
The bench builds the block with its default parameters: 4-bit symbols, 15-symbol blocks, four roots and the polynomial x^4+x+1. These values make true codewords available as shifted and scaled copies of the generator polynomial, so the zero-syndrome path can be checked alongside random blocks and single-symbol errors. The bench computes reference syndromes by direct power-sum evaluation. It checks them against the design across stalls, aborted partial blocks, stray symbols outside a block, and blocks sent back to back.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    // Multiply two field elements of width w, reducing by poly (w+1 bits).
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                          input int w, input logic [8:0] poly);
        logic [8:0] sh;
        logic [7:0] acc;
        sh  = {1'b0, a};
        acc = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < w) begin
                if (b[i]) acc = acc ^ sh[7:0];
                sh = sh << 1;
                if (sh[w]) sh = sh ^ poly;
            end
        end
        return acc;
    endfunction

    // Raise base to the power e.
    function automatic logic [7:0] gf_pow(input logic [7:0] base, input int e,
                                          input int w, input logic [8:0] poly);
        logic [7:0] r;
        r = 8'd1;
        for (int i = 0; i < e; i++) r = gf_mul(r, base, w, poly);
        return r;
    endfunction

endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul #(
    parameter int          W    = 4,
    parameter logic [8:0]  POLY = 9'h013,
    parameter logic [7:0]  ROOT = 8'd2
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    import rs_syn_pkg::*;

    localparam int ENTRIES = 2 ** W;

    function automatic logic [ENTRIES*W-1:0] build_table();
        logic [ENTRIES*W-1:0] t;
        logic [7:0]           p;
        t = '0;
        for (int v = 0; v < ENTRIES; v++) begin
            p = gf_mul(8'(v), ROOT, W, POLY);
            t[v*W +: W] = p[W-1:0];
        end
        return t;
    endfunction

    localparam logic [ENTRIES*W-1:0] TABLE = build_table();

    assign dout = TABLE[din*W +: W];
endmodule

// File: rtl/syn_cell.sv
module syn_cell #(
    parameter int          W    = 4,
    parameter logic [8:0]  POLY = 9'h013,
    parameter logic [7:0]  ROOT = 8'd1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc_next
);
    typedef struct packed {
        logic [W-1:0] acc;
    } cell_t;

    cell_t        st_d, st_q;
    logic [W-1:0] scaled;

    generate
        if (ROOT == 8'd1) begin : g_plain
            assign scaled = st_q.acc;
        end else begin : g_table
            gf_const_mul #(.W(W), .POLY(POLY), .ROOT(ROOT)) mul_i (
                .din  (st_q.acc),
                .dout (scaled)
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (clr) st_d.acc = din;
            else     st_d.acc = scaled ^ din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_next = st_d.acc;

    // R6: a start-of-block symbol becomes the accumulator contents.
    p_clear_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (st_q.acc == $past(din)));

    // R5: without an accepted symbol the accumulator holds.
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.acc));
endmodule

// File: rtl/syn_ctrl.sv
module syn_ctrl #(
    parameter int N_SYM = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_sob,
    output logic accept,
    output logic clr,
    output logic last
);
    localparam int CNT_W = $clog2(N_SYM + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_SYM);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        accept  = sym_valid && (sym_sob || st_q.open);
        clr     = sym_valid && sym_sob;
        cnt_inc = clr ? CNT_W'(1) : st_q.cnt + CNT_W'(1);
        last    = accept && (cnt_inc == LAST_CNT);
        if (accept) begin
            st_d.cnt  = last ? '0 : cnt_inc;
            st_d.open = !last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < LAST_CNT);

    p_sob_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_sob && N_SYM > 1) |=> (st_q.open && st_q.cnt == CNT_W'(1)));

    p_closed_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && sym_valid && !sym_sob) |-> !accept);
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
    parameter int         SYM_W  = 4,
    parameter int         N_SYM  = 15,
    parameter int         N_ROOT = 4,
    parameter logic [8:0] POLY   = 9'h013
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_valid,
    input  logic                     sym_sob,
    input  logic [SYM_W-1:0]         sym_data,
    output logic                     syn_valid,
    output logic [N_ROOT*SYM_W-1:0]  syn_out,
    output logic                     no_err
);
    import rs_syn_pkg::*;

    localparam int SYN_W = N_ROOT * SYM_W;

    typedef struct packed {
        logic [SYN_W-1:0] syn;
        logic             vld;
        logic             zero;
    } out_t;

    out_t             st_d, st_q;
    logic             accept, clr, last;
    logic [SYN_W-1:0] acc_all;

    syn_ctrl #(.N_SYM(N_SYM)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_sob   (sym_sob),
        .accept    (accept),
        .clr       (clr),
        .last      (last)
    );

    generate
        for (genvar j = 0; j < N_ROOT; j++) begin : g_root
            localparam logic [7:0] ROOT_J = gf_pow(8'd2, j, SYM_W, POLY);
            syn_cell #(.W(SYM_W), .POLY(POLY), .ROOT(ROOT_J)) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (accept),
                .clr      (clr),
                .din      (sym_data),
                .acc_next (acc_all[j*SYM_W +: SYM_W])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = last;
        if (last) begin
            st_d.syn  = acc_all;
            st_d.zero = ~|acc_all;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign syn_valid = st_q.vld;
    assign syn_out   = st_q.syn;
    assign no_err    = st_q.zero;

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid && N_SYM > 1) |=> !syn_valid);

    p_last_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> syn_valid);

    p_noerr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid |-> (no_err == (syn_out == '0)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_valid |-> ($stable(syn_out) && $stable(no_err)));
endmodule

// File: tb/rs_syndrome_calc_tb_top.sv
module rs_syndrome_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        sym_sob = 1'b0;
    logic [3:0]  sym_data = '0;
    logic        syn_valid;
    logic [15:0] syn_out;
    logic        no_err;

    always #2 clk = ~clk;

    rs_syndrome_calc dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_sob(sym_sob),
        .sym_data(sym_data), .syn_valid(syn_valid), .syn_out(syn_out), .no_err(no_err)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_pulse = 0;
    int n_exp = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_syn = '0;
    logic [3:0]  blk [15];
    logic [3:0]  gpoly [5];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gm(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] p = 0;
        logic [3:0] x = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) p ^= x;
            x = x[3] ? ((x << 1) ^ 4'h3) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [3:0] gp(input int e);
        logic [3:0] r = 4'd1;
        for (int i = 0; i < (e % 15); i++) r = gm(r, 4'd2);
        return r;
    endfunction

    function automatic logic [15:0] ref_syn();
        logic [15:0] s = 0;
        for (int j = 0; j < 4; j++) begin
            logic [3:0] acc = 0;
            for (int i = 0; i < 15; i++) acc ^= gm(blk[i], gp(j * (14 - i)));
            s[j*4 +: 4] = acc;
        end
        return s;
    endfunction

    // Drive one symbol per accepted cycle; gaps inserts idle cycles (R5).
    task automatic send_block(input int gaps);
        exp_q.push_back(ref_syn());
        n_exp++;
        for (int i = 0; i < 15; i++) begin
            for (int g = 0; g < gaps; g++) begin
                @(negedge clk); sym_valid = 0; sym_sob = 0; sym_data = 4'hF;
            end
            @(negedge clk);
            sym_valid = 1; sym_sob = (i == 0); sym_data = blk[i];
        end
        @(negedge clk); sym_valid = 0; sym_sob = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sym_valid = 0; sym_sob = 0;
        end
    endtask

    // Monitor: pops expected syndromes at each result pulse (R2, R3, R4).
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && syn_valid) begin
                n_pulse++;
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected pulse", 32'(syn_out), 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    last_syn = e;
                    check(syn_out == e, "R2 syndromes", 32'(syn_out), 32'(e));
                    check(no_err == (e == 0), "R4 no_err", 32'(no_err), 32'(e == 0));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // generator polynomial g(x) = prod (x + 2^j), index = degree
        gpoly = '{4'd1, 4'd0, 4'd0, 4'd0, 4'd0};
        for (int j = 0; j < 4; j++) begin
            logic [3:0] r = gp(j);
            for (int d = 4; d >= 0; d--)
                gpoly[d] = (d > 0 ? gpoly[d-1] : 4'd0) ^ gm(gpoly[d], r);
        end

        repeat (3) @(negedge clk);
        check(syn_valid == 0 && syn_out == 0 && no_err == 0, "R1 reset state",
              {15'd0, syn_valid, syn_out}, 0);
        rst_n = 1;
        idle(2);
        check(syn_valid == 0 && syn_out == 0 && no_err == 0, "R1 after reset",
              {15'd0, syn_valid, syn_out}, 0);

        // R2: all-zero block -> no error
        for (int i = 0; i < 15; i++) blk[i] = 0;
        send_block(0); idle(3);

        // R2: single symbol at highest degree (first received)
        for (int i = 0; i < 15; i++) blk[i] = 0;
        blk[0] = 4'h7;
        send_block(0); idle(3);

        // R4: shifted and scaled codewords give zero syndromes
        for (int k = 0; k < 11; k += 5) begin
            for (int i = 0; i < 15; i++) begin
                int d = 14 - i - k;
                blk[i] = (d >= 0 && d <= 4) ? gm(gpoly[d], 4'(k + 3)) : 4'd0;
            end
            send_block(0); idle(2);
            blk[7] ^= 4'h5;       // one corrupted symbol: nonzero syndromes
            send_block(0); idle(2);
        end

        // R5: random block with stalls between symbols
        for (int i = 0; i < 15; i++) blk[i] = 4'($urandom);
        send_block(2); idle(3);

        // R6: aborted partial block then full block restarts
        @(negedge clk); sym_valid = 1; sym_sob = 1; sym_data = 4'hA;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sym_valid = 1; sym_sob = 0; sym_data = 4'(i + 1);
        end
        for (int i = 0; i < 15; i++) blk[i] = 4'($urandom);
        send_block(0); idle(3);

        // R7/R9: stray symbols with no block open; outputs must hold
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); sym_valid = 1; sym_sob = 0; sym_data = 4'($urandom);
        end
        idle(3);
        check(syn_out == last_syn, "R7 stray symbols ignored", 32'(syn_out), 32'(last_syn));
        check(syn_valid == 0, "R9 no pulse while idle", 32'(syn_valid), 0);

        // R8: back-to-back blocks with no gap
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 15; i++) blk[i] = 4'($urandom);
            exp_q.push_back(ref_syn()); n_exp++;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk); sym_valid = 1; sym_sob = (i == 0); sym_data = blk[i];
            end
        end
        idle(4);
        check(syn_out == last_syn, "R9 hold after last block", 32'(syn_out), 32'(last_syn));

        check(n_pulse == n_exp, "R3 pulse count", 32'(n_pulse), 32'(n_exp));
        check(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule